// File: doc/BRIEF.md
# Asynchronous Memory Bank Timing Sequencer

This block runs single read and write cycles against one external asynchronous memory bank. An internal requester raises `req` with an address, a direction flag and write data. The sequencer then runs three phases on the external pins. First comes an address-setup phase with chip select low. Next is a strobe phase, where the read or write enable is driven low. Last is a hold phase with chip select still low. It then pulses `ack` for one cycle. On a read, it returns the data it sampled on the last strobe clock.

All phase lengths come from a 32-bit timing word. Reads and writes have separate setup, strobe and hold fields. The encodings differ by phase: setup counts exact clocks, while strobe and hold count field-plus-one clocks. An external wait input can stretch the strobe phase, but only when extension is enabled and the bank is in SRAM mode. The wait input goes through a one- or two-flop synchroniser, selected by a bit in the timing word. The device-width and mode fields are decoded and reported at ports, not acted on. A reserved code in either field raises a sticky error and keeps accesses from starting.

Top module: `amb_sequencer`

## Requirements
- R1: The timing word resets to 0x3FFFFFF2. So after reset `cfg_size`=2, `cfg_mode`=0, `cfg_err`=0, and a read has setup 15, strobe 64 and hold 8 clocks. A `cfg_we` pulse loads `cfg_wdata` only when no access is running or being accepted. Otherwise it is ignored. `cfg_size` reports bits 1:0 and `cfg_mode` reports bits 3:2.
- R2: The setup phase has chip select low and both enables high. It lasts bits 16:13 clocks for a read and bits 29:26 clocks for a write. A value of 0 leaves out the phase.
- R3: The strobe phase lasts field+1 clocks. For a read, the field is bits 12:7 and `mem_re_n` is low. For a write, the field is bits 25:20 and `mem_we_n` is low. A field of 0 is used as 1, so the strobe is never shorter than 2 clocks.
- R4: The hold phase has chip select low and both enables high. It lasts bits 6:4 +1 clocks for a read and bits 19:17 +1 clocks for a write.
- R5: Chip select is low exactly over setup, strobe and hold. `mem_addr` and `mem_wdata` hold the values captured at acceptance throughout the access. Only the enable that matches the direction ever goes low, and never both at once.
- R6: A read captures `mem_rdata` on the last strobe clock, and `rsp_rdata` shows that value when `ack` is high.
- R7: A request is accepted on a clock where the block is idle and `req` is high. `ack` is high for exactly one cycle, the first one after the last hold clock.
- R8: When bit 30 is 1 and the mode is 00 (SRAM), the strobe phase runs its programmed length. It then continues for as long as the synchronised wait is high.
- R9: When bit 30 is 0, or the mode is not 00, the wait input has no effect on access length.
- R10: When bit 31 is 0, the wait input reaches the sequencer through two flops. When it is 1, it goes through one flop. Releasing wait in strobe clock c therefore ends the extended strobe after clock c+2 or c+1.
- R11: Loading a size of 11 or a mode of 10 sets `cfg_err`, which stays set until reset. While the current word holds such a code, no access starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Load strobe for the timing word |
| cfg_wdata | input | 32 | Timing word to load |
| cfg_size | output | 2 | Decoded device-width field |
| cfg_mode | output | 2 | Decoded bank-mode field |
| cfg_err | output | 1 | Sticky reserved-code flag |
| req | input | 1 | Access request, held until ack |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW | Access address |
| req_wdata | input | DW | Write data |
| ack | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | DW | Read result |
| mem_cs_n | output | 1 | Chip select, active low |
| mem_re_n | output | 1 | Read enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_addr | output | AW | Address to the bank |
| mem_wdata | output | DW | Data to the bank |
| mem_rdata | input | DW | Data from the bank |
| mem_wait | input | 1 | Asynchronous wait from the bank |

## Verification
Some properties are checked on every cycle:
- the two enables never go low together;
- a strobe never falls outside chip select;
- address and write data stay still while chip select is low;
- `ack` never lasts two cycles;
- a strobe always lasts at least two clocks;
- the error flag never clears;
- no access leaves idle under a reserved code;
- the strobe ends on time when extension is inactive.

Only the bench scenarios can show other behaviour:
- exact setup, strobe and hold lengths for both directions;
- read data taken from the last strobe clock;
- the one-flop and two-flop wait latencies;
- the timing word refusing a load during a running access.

// File: rtl/amb_pkg.sv
// Package for the asynchronous memory bank sequencer.
// Holds the timing-word layout, the decoded configuration type, the phase
// encoding and the counter width derived from the field widths.
package amb_pkg;

    localparam int CFG_W     = 32;
    localparam int SZ_LSB    = 0;
    localparam int SZ_W      = 2;
    localparam int MD_LSB    = 2;
    localparam int MD_W      = 2;
    localparam int RH_LSB    = 4;
    localparam int H_W       = 3;
    localparam int RS_LSB    = 7;
    localparam int S_W       = 6;
    localparam int RSU_LSB   = 13;
    localparam int SU_W      = 4;
    localparam int WH_LSB    = 17;
    localparam int WS_LSB    = 20;
    localparam int WSU_LSB   = 26;
    localparam int WEXT_BIT  = 30;
    localparam int WSYNC_BIT = 31;

    localparam logic [CFG_W-1:0] CFG_RST = 32'h3FFF_FFF2;

    localparam logic [SZ_W-1:0] SIZE_RSVD = 2'b11;
    localparam logic [MD_W-1:0] MODE_SRAM = 2'b00;
    localparam logic [MD_W-1:0] MODE_RSVD = 2'b10;

    // Number of flops in the wait synchroniser chain (one or all are tapped)
    localparam int SYNC_STAGES = 2;

    // Counter must hold the widest of the three phase loads
    localparam int CNT_W = (S_W > SU_W) ? ((S_W > H_W) ? S_W : H_W)
                                        : ((SU_W > H_W) ? SU_W : H_W);

    typedef struct packed {
        logic            wsync1;
        logic            wext;
        logic [SU_W-1:0] wsu;
        logic [S_W-1:0]  wstrb;
        logic [H_W-1:0]  whold;
        logic [SU_W-1:0] rsu;
        logic [S_W-1:0]  rstrb;
        logic [H_W-1:0]  rhold;
        logic [MD_W-1:0] mode;
        logic [SZ_W-1:0] size;
    } cfg_t;

    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_SETUP  = 2'd1,
        PH_STROBE = 2'd2,
        PH_HOLD   = 2'd3
    } phase_e;

    // Split a raw timing word into named fields
    function automatic cfg_t unpack_cfg(input logic [CFG_W-1:0] w);
        cfg_t c;
        c.size   = w[SZ_LSB  +: SZ_W];
        c.mode   = w[MD_LSB  +: MD_W];
        c.rhold  = w[RH_LSB  +: H_W];
        c.rstrb  = w[RS_LSB  +: S_W];
        c.rsu    = w[RSU_LSB +: SU_W];
        c.whold  = w[WH_LSB  +: H_W];
        c.wstrb  = w[WS_LSB  +: S_W];
        c.wsu    = w[WSU_LSB +: SU_W];
        c.wext   = w[WEXT_BIT];
        c.wsync1 = w[WSYNC_BIT];
        return c;
    endfunction

    // True when a word carries a reserved width or mode code
    function automatic logic has_rsvd(input logic [CFG_W-1:0] w);
        return (w[SZ_LSB +: SZ_W] == SIZE_RSVD) || (w[MD_LSB +: MD_W] == MODE_RSVD);
    endfunction

endpackage

// File: rtl/amb_cfg_reg.sv
// Timing-word register with a sticky reserved-code flag.
// Assumes: 'busy' is high whenever an access is running or being accepted;
// loads arriving then are dropped so a running access never sees a change.
module amb_cfg_reg
    import amb_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CFG_W-1:0] load_word,
    input  logic             busy,
    output cfg_t             cfg,
    output logic             cfg_ok,
    output logic             cfg_err
);

    logic [CFG_W-1:0] word_q;
    logic             take;

    assign take = load && !busy;

    // Hold the active timing word; reload only while idle
    always_ff @(posedge clk) begin
        if (!rst_n)    word_q <= CFG_RST;
        else if (take) word_q <= load_word;
    end

    // Record any accepted load carrying a reserved code until reset
    always_ff @(posedge clk) begin
        if (!rst_n)                          cfg_err <= 1'b0;
        else if (take && has_rsvd(load_word)) cfg_err <= 1'b1;
    end

    // Decode fields and validity of the active word
    always_comb begin
        cfg    = unpack_cfg(word_q);
        cfg_ok = !has_rsvd(word_q);
    end

    AST_CFG_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err |=> cfg_err);                                           // R11
    AST_CFG_FROZEN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(word_q));                                      // R1

endmodule

// File: rtl/amb_wait_sync.sv
// Synchroniser chain for the asynchronous wait input.
// Output taps the first flop when 'tap_first' is set, else the last flop.
// Assumes: STAGES >= 2; chain resets to the released (low) state.
module amb_wait_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    input  logic tap_first,
    output logic synced
);

    logic [STAGES-1:0] chain;

    for (genvar i = 0; i < STAGES; i++) begin : g_stage
        if (i == 0) begin : g_head
            // First flop samples the raw pin
            always_ff @(posedge clk) begin
                if (!rst_n) chain[0] <= 1'b0;
                else        chain[0] <= async_in;
            end
        end else begin : g_tail
            // Later flops shift the previous stage along
            always_ff @(posedge clk) begin
                if (!rst_n) chain[i] <= 1'b0;
                else        chain[i] <= chain[i-1];
            end
        end
    end

    assign synced = tap_first ? chain[0] : chain[STAGES-1];

    AST_SYNC_ONE_FLOP: assert property (@(posedge clk) disable iff (!rst_n)
        (tap_first && $past(tap_first) && $past(rst_n)) |-> (synced == $past(async_in))); // R10

endmodule

// File: rtl/amb_phase_fsm.sv
// Phase sequencer: idle -> setup -> strobe (+wait) -> hold -> idle.
// Setup loads field-1 (skipped at 0), strobe loads max(field,1), hold
// loads field; each phase ends when its down-counter reaches zero.
// Assumes: timing word is stable during an access (see amb_cfg_reg).
module amb_phase_fsm
    import amb_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   req,
    input  logic   req_we,
    input  cfg_t   cfg,
    input  logic   cfg_ok,
    input  logic   wait_s,
    output phase_e phase,
    output logic   is_wr,
    output logic   accept,
    output logic   last_strobe,
    output logic   ack
);

    logic [CNT_W-1:0] cnt, cnt_nxt;
    logic [CNT_W-1:0] su_len, st_len, ho_len;
    logic [S_W-1:0]   st_raw;
    phase_e           ph_nxt;
    logic             dir, wr_nxt, ack_nxt, wait_hold, wait_armed;

    assign dir        = (phase == PH_IDLE) ? req_we : is_wr;
    assign wait_armed = cfg.wext && (cfg.mode == MODE_SRAM);
    assign wait_hold  = wait_armed && wait_s;
    assign accept     = (phase == PH_IDLE) && req && cfg_ok;
    assign last_strobe = (phase == PH_STROBE) && (cnt == '0) && !wait_hold;

    // Select phase lengths for the direction in force
    always_comb begin
        su_len = CNT_W'(dir ? cfg.wsu : cfg.rsu);
        st_raw = dir ? cfg.wstrb : cfg.rstrb;
        st_len = (st_raw == '0) ? CNT_W'(1) : CNT_W'(st_raw);
        ho_len = CNT_W'(dir ? cfg.whold : cfg.rhold);
    end

    // Next phase, counter and completion pulse
    always_comb begin
        ph_nxt  = phase;
        cnt_nxt = cnt;
        wr_nxt  = is_wr;
        ack_nxt = 1'b0;
        case (phase)
            PH_IDLE: begin
                if (accept) begin
                    wr_nxt = req_we;
                    if (su_len != '0) begin
                        ph_nxt  = PH_SETUP;
                        cnt_nxt = su_len - CNT_W'(1);
                    end else begin
                        ph_nxt  = PH_STROBE;
                        cnt_nxt = st_len;
                    end
                end
            end
            PH_SETUP: begin
                if (cnt == '0) begin
                    ph_nxt  = PH_STROBE;
                    cnt_nxt = st_len;
                end else begin
                    cnt_nxt = cnt - CNT_W'(1);
                end
            end
            PH_STROBE: begin
                if (cnt != '0) begin
                    cnt_nxt = cnt - CNT_W'(1);
                end else if (!wait_hold) begin
                    ph_nxt  = PH_HOLD;
                    cnt_nxt = ho_len;
                end
            end
            PH_HOLD: begin
                if (cnt == '0) begin
                    ph_nxt  = PH_IDLE;
                    ack_nxt = 1'b1;
                end else begin
                    cnt_nxt = cnt - CNT_W'(1);
                end
            end
            default: ph_nxt = PH_IDLE;
        endcase
    end

    // State registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= PH_IDLE;
            cnt   <= '0;
            is_wr <= 1'b0;
            ack   <= 1'b0;
        end else begin
            phase <= ph_nxt;
            cnt   <= cnt_nxt;
            is_wr <= wr_nxt;
            ack   <= ack_nxt;
        end
    end

    AST_ACK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        ack |=> !ack);                                                  // R7
    AST_NO_START_RSVD: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_IDLE && !cfg_ok) |=> (phase == PH_IDLE));          // R11
    AST_STROBE_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(phase == PH_STROBE) |=> (phase == PH_STROBE));            // R3
    AST_WAIT_INERT: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_STROBE && cnt == '0 && !wait_armed) |=> (phase == PH_HOLD)); // R9

endmodule

// File: rtl/amb_sequencer.sv
// Top of the asynchronous memory bank sequencer.
// Captures the request at acceptance, drives the bank pins from the phase
// state, samples read data on the last strobe clock and reports config.
// Assumes: requester keeps req high until ack and drops it in the ack cycle.
module amb_sequencer
    import amb_pkg::*;
#(
    parameter int AW = 24,
    parameter int DW = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [CFG_W-1:0] cfg_wdata,
    output logic [SZ_W-1:0]  cfg_size,
    output logic [MD_W-1:0]  cfg_mode,
    output logic             cfg_err,
    input  logic             req,
    input  logic             req_we,
    input  logic [AW-1:0]    req_addr,
    input  logic [DW-1:0]    req_wdata,
    output logic             ack,
    output logic [DW-1:0]    rsp_rdata,
    output logic             mem_cs_n,
    output logic             mem_re_n,
    output logic             mem_we_n,
    output logic [AW-1:0]    mem_addr,
    output logic [DW-1:0]    mem_wdata,
    input  logic [DW-1:0]    mem_rdata,
    input  logic             mem_wait
);

    cfg_t   cfg;
    phase_e phase;
    logic   cfg_ok, busy, accept, last_strobe, is_wr, wait_s;

    assign busy = (phase != PH_IDLE) || accept;

    amb_cfg_reg u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (cfg_we),
        .load_word (cfg_wdata),
        .busy      (busy),
        .cfg       (cfg),
        .cfg_ok    (cfg_ok),
        .cfg_err   (cfg_err)
    );

    amb_wait_sync #(.STAGES(SYNC_STAGES)) u_wsync (
        .clk       (clk),
        .rst_n     (rst_n),
        .async_in  (mem_wait),
        .tap_first (cfg.wsync1),
        .synced    (wait_s)
    );

    amb_phase_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .req         (req),
        .req_we      (req_we),
        .cfg         (cfg),
        .cfg_ok      (cfg_ok),
        .wait_s      (wait_s),
        .phase       (phase),
        .is_wr       (is_wr),
        .accept      (accept),
        .last_strobe (last_strobe),
        .ack         (ack)
    );

    // Latch address and write data when a request is taken
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem_addr  <= '0;
            mem_wdata <= '0;
        end else if (accept) begin
            mem_addr  <= req_addr;
            mem_wdata <= req_wdata;
        end
    end

    // Sample bank data at the end of the final read strobe clock
    always_ff @(posedge clk) begin
        if (!rst_n)                     rsp_rdata <= '0;
        else if (last_strobe && !is_wr) rsp_rdata <= mem_rdata;
    end

    // Pin decode from the registered phase
    always_comb begin
        mem_cs_n = (phase == PH_IDLE);
        mem_re_n = !((phase == PH_STROBE) && !is_wr);
        mem_we_n = !((phase == PH_STROBE) && is_wr);
        cfg_size = cfg.size;
        cfg_mode = cfg.mode;
    end

    AST_ENABLES_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_re_n || mem_we_n));                                        // R5
    AST_STROBE_INSIDE_CS: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_re_n || !mem_we_n) |-> !mem_cs_n);                        // R5
    AST_BUS_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_cs_n && $past(!mem_cs_n)) |-> ($stable(mem_addr) && $stable(mem_wdata))); // R5

endmodule

// File: tb/amb_sequencer_bench.sv
// Bench: directed corners plus seeded random accesses, checked against
// phase lengths computed from the timing word by bench functions.
module amb_sequencer_bench;

    localparam int AW = 24;
    localparam int DW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_we = 1'b0;
    logic [31:0]   cfg_wdata = '0;
    logic [1:0]    cfg_size, cfg_mode;
    logic          cfg_err;
    logic          req = 1'b0, req_we = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic          ack;
    logic [DW-1:0] rsp_rdata;
    logic          mem_cs_n, mem_re_n, mem_we_n;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_wdata;
    logic [DW-1:0] mem_rdata = '0;
    logic          mem_wait = 1'b0;

    int errors = 0;
    int checks = 0;
    bit done = 0;
    logic [31:0] cur_cfg = 32'h3FFF_FFF2;

    always #5 clk = ~clk;

    amb_sequencer #(.AW(AW), .DW(DW)) u_amb_sequencer (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .cfg_size(cfg_size), .cfg_mode(cfg_mode), .cfg_err(cfg_err),
        .req(req), .req_we(req_we), .req_addr(req_addr), .req_wdata(req_wdata),
        .ack(ack), .rsp_rdata(rsp_rdata), .mem_cs_n(mem_cs_n),
        .mem_re_n(mem_re_n), .mem_we_n(mem_we_n), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_wait(mem_wait)
    );

    task automatic check(input bit ok, input string tag, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    function automatic int fld(input logic [31:0] w, input int lsb, input int wd);
        return int'((w >> lsb) & ((32'd1 << wd) - 32'd1));
    endfunction
    function automatic int exp_setup(input logic [31:0] w, input bit we);
        return we ? fld(w, 26, 4) : fld(w, 13, 4);
    endfunction
    function automatic int exp_strobe(input logic [31:0] w, input bit we);
        int s = we ? fld(w, 20, 6) : fld(w, 7, 6);
        return ((s == 0) ? 1 : s) + 1;
    endfunction
    function automatic int exp_hold(input logic [31:0] w, input bit we);
        return (we ? fld(w, 17, 3) : fld(w, 4, 3)) + 1;
    endfunction
    function automatic logic [31:0] mk_cfg(input int sz, md, rh, rs, rsu, wh, ws, wsu,
                                           input bit ext, input bit s1);
        logic [31:0] w;
        w = {s1, ext, 4'(wsu), 6'(ws), 3'(wh), 4'(rsu), 6'(rs), 3'(rh), 2'(md), 2'(sz)};
        return w;
    endfunction

    task automatic load_cfg(input logic [31:0] w);
        @(negedge clk);
        cfg_we = 1'b1; cfg_wdata = w;
        @(negedge clk);
        cfg_we = 1'b0;
        cur_cfg = w;
    endtask

    // One access; drop_at>0 holds wait high until that strobe clock
    task automatic run_access(input bit we, input int drop_at, input string tag);
        int n_su = 0, n_st = 0, n_ho = 0, n_cs = 0, cyc = 0, prog, exp_st, lat;
        bit seen = 0, got_ack = 0, bus_ok = 1, eff;
        logic [AW-1:0] a;
        logic [DW-1:0] d, base;
        logic [31:0] c = cur_cfg;
        a = AW'($urandom); d = $urandom; base = $urandom;
        if (drop_at > 0) begin
            mem_wait = 1'b1;
            repeat (3) @(negedge clk);
        end
        @(negedge clk);
        req = 1'b1; req_we = we; req_addr = a; req_wdata = d;
        while (cyc < 3000) begin
            @(negedge clk);
            cyc++;
            if (ack) begin got_ack = 1; break; end
            if (!mem_cs_n) begin
                n_cs++;
                if (n_cs == 1) begin req_addr = AW'($urandom); req_wdata = $urandom; end
                if (mem_addr != a) bus_ok = 0;
                if (we && mem_wdata != d) bus_ok = 0;
                if (!mem_re_n || !mem_we_n) begin
                    n_st++; seen = 1;
                    if (we ? !mem_re_n : !mem_we_n) bus_ok = 0;
                    if (!mem_re_n) mem_rdata = base + DW'(n_st);
                    if (n_st == drop_at) mem_wait = 1'b0;
                end else begin
                    mem_rdata = $urandom;
                    if (!seen) n_su++; else n_ho++;
                end
            end
        end
        req = 1'b0;
        mem_wait = 1'b0;
        prog = exp_strobe(c, we);
        lat  = c[31] ? 1 : 2;
        eff  = (drop_at > 0) && c[30] && (c[3:2] == 2'b00);
        exp_st = (eff && drop_at + lat > prog) ? drop_at + lat : prog;
        check(got_ack, "R7", {tag, " ack seen"}, got_ack, 1);
        check(n_su == exp_setup(c, we), "R2", {tag, " setup clocks"}, n_su, exp_setup(c, we));
        check(n_st == exp_st, "R3", {tag, " strobe clocks"}, n_st, exp_st);
        check(n_ho == exp_hold(c, we), "R4", {tag, " hold clocks"}, n_ho, exp_hold(c, we));
        check(bus_ok && n_cs == n_su + n_st + n_ho, "R5", {tag, " cs span/bus"}, n_cs, n_su + n_st + n_ho);
        if (!we)
            check(rsp_rdata == base + DW'(n_st), "R6", {tag, " read data"}, rsp_rdata, base + DW'(n_st));
        @(negedge clk);
        check(!ack && mem_cs_n, "R7", {tag, " ack one cycle"}, ack, 0);
    endtask

    // Watchdog: a hang is a failed check and still reaches the summary
    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [31:0] w;
        int p, m, drop;
        void'($urandom(32'd20240611));
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(cfg_size == 2'd2, "R1", "reset size", cfg_size, 2);
        check(cfg_mode == 2'd0, "R1", "reset mode", cfg_mode, 0);
        check(!cfg_err, "R1", "reset err", cfg_err, 0);
        check(mem_cs_n && mem_re_n && mem_we_n && !ack, "R1", "reset pins idle", mem_cs_n, 1);
        run_access(1'b0, -1, "R1 default read");

        // R2/R3 skipped setup and zero strobe field
        load_cfg(mk_cfg(0, 0, 2, 0, 0, 1, 0, 0, 0, 0));
        check(cfg_size == 2'd0 && cfg_mode == 2'd0, "R1", "size/mode report", cfg_size, 0);
        run_access(1'b0, -1, "R2 R3 zero read");
        run_access(1'b1, -1, "R2 R3 zero write");
        load_cfg(mk_cfg(1, 3, 5, 9, 3, 6, 4, 7, 0, 0));
        check(cfg_size == 2'd1 && cfg_mode == 2'd3, "R1", "size/mode report 2", {cfg_size, cfg_mode}, 7);
        run_access(1'b1, -1, "R4 write");
        run_access(1'b0, -1, "R4 read");

        // R1 load ignored while busy
        fork
            run_access(1'b0, -1, "R1 busy");
            begin
                repeat (4) @(negedge clk);
                cfg_we = 1'b1; cfg_wdata = mk_cfg(0, 1, 0, 2, 0, 0, 2, 0, 0, 0);
                @(negedge clk);
                cfg_we = 1'b0;
            end
        join
        check(cfg_size == 2'd1 && cfg_mode == 2'd3, "R1", "busy load dropped", {cfg_size, cfg_mode}, 7);

        // R8/R10 wait extension, two-flop and one-flop
        load_cfg(mk_cfg(0, 0, 1, 3, 2, 1, 3, 2, 1, 0));
        run_access(1'b0, 6, "R8 R10 sync2 read");
        run_access(1'b1, 7, "R8 R10 sync2 write");
        load_cfg(mk_cfg(0, 0, 1, 3, 2, 1, 3, 2, 1, 1));
        run_access(1'b0, 6, "R8 R10 sync1 read");
        // R9 wait ignored: extension off, or non-SRAM mode
        load_cfg(mk_cfg(0, 0, 1, 3, 2, 1, 3, 2, 0, 1));
        run_access(1'b0, 9, "R9 ext off");
        load_cfg(mk_cfg(0, 1, 1, 3, 2, 1, 3, 2, 1, 1));
        run_access(1'b1, 9, "R9 rom mode");

        // R11 reserved codes
        load_cfg(mk_cfg(3, 0, 1, 1, 1, 1, 1, 1, 0, 0));
        check(cfg_err, "R11", "err on rsvd size", cfg_err, 1);
        req = 1'b1; req_we = 1'b0;
        m = 0;
        repeat (20) begin @(negedge clk); if (!mem_cs_n || ack) m++; end
        req = 1'b0;
        check(m == 0, "R11", "no access rsvd size", m, 0);
        load_cfg(mk_cfg(0, 2, 1, 1, 1, 1, 1, 1, 0, 0));
        req = 1'b1;
        m = 0;
        repeat (20) begin @(negedge clk); if (!mem_cs_n || ack) m++; end
        req = 1'b0;
        check(m == 0, "R11", "no access rsvd mode", m, 0);
        load_cfg(mk_cfg(2, 0, 1, 2, 1, 1, 2, 1, 0, 0));
        check(cfg_err, "R11", "err sticky", cfg_err, 1);
        run_access(1'b0, -1, "R11 after valid");

        // Random timing words and wait scenarios
        for (int i = 0; i < 50; i++) begin
            bit we;
            w = $urandom;
            w[1:0] = 2'($urandom % 3);
            m = $urandom % 3;
            w[3:2] = (m == 2) ? 2'b11 : 2'(m);
            load_cfg(w);
            we = 1'($urandom);
            p = exp_strobe(w, we);
            drop = -1;
            if ($urandom % 3 == 0) begin
                drop = p + int'($urandom % 4) - 1;
                if (drop < 1) drop = 1;
            end
            run_access(we, drop, "R8 R9 random");
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule